// File: doc/BRIEF.md
# Seven-Segment Millisecond Timer with Alarm Line

This block is a free-running decimal stopwatch that counts from 00.000 s to 99.999 s in steps of one millisecond and then starts over, without end. The count is held as five BCD digits (tens of seconds, units of seconds, and three millisecond digits). It is shown on five multiplexed seven-segment digits, and a decimal point separates seconds from milliseconds.

A parameterised prescaler turns the system clock into the one-millisecond step. A scan counter lights one digit at a time. Each digit gets its own segment pattern, and the decimal point is lit only on the units-of-seconds position.

An alarm line rises on the very step that the count shows 50.000 s. It stays high through 50.999 s, so it is high for exactly one second of displayed time. A test rig can use this line as a trigger that is locked to a known value on the display.

Top module: `ms_seg_timer`

## Requirements
- R1: While `rst` is high at a rising clock edge, the count becomes 00.000, `alarm` goes low and the scan returns to digit 0 (`dig_en` = 5'b00001).
- R2: Outside reset, the count advances by exactly one millisecond once every `CLK_PER_MS` clock cycles and holds its value in between.
- R3: The count is decimal. Digit i shows (count_ms / 10^i) mod 10, where digit 0 is milliseconds units and digit 4 is tens of seconds. A digit at 9 carries into the next digit.
- R4: After 99.999 the next step shows 00.000.
- R5: `alarm` goes high in the same clock cycle that the count becomes 50.000.
- R6: `alarm` stays high for displayed values 50.000 through 50.999 and drops when the count reaches 51.000. That is exactly 1000 × `CLK_PER_MS` cycles per lap.
- R7: `dig_en` is one-hot, with bit i enabling digit i. The active digit moves 0,1,2,3,4,0,… and advances once every `SCAN_DIV` clock cycles.
- R8: `seg` is active-high with bit 0 = a through bit 6 = g. The codes for digits 0..9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F (hex).
- R9: `dp` is high exactly when digit 3 (units of seconds) is enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| seg | output | 7 | Segment lines for the enabled digit, gfedcba, active high |
| dig_en | output | 5 | One-hot digit enable, bit 0 = milliseconds units |
| dp | output | 1 | Decimal point, lit on the units-of-seconds digit |
| alarm | output | 1 | High while the count is within 50.000..50.999 |

## Verification
The assertions assume that `rst` is held high for at least one clock edge before any property is evaluated. They also assume that `CLK_PER_MS` and `SCAN_DIV` are at least 1, so the step and scan strobes are well defined. The stimulus respects both assumptions: reset opens every run and is pulsed again only as a whole clock cycle.

One instance runs with a step on every cycle, so a full 100-second lap fits in the run. On that lap the bench watches the alarm edges and the wrap from 99.999 to 00.000. A second instance uses a prescaler of four, which exercises the hold between steps.

// File: rtl/ms_seg_timer.sv
module ms_seg_timer #(
  parameter int CLK_PER_MS = 50000,
  parameter int SCAN_DIV   = 10000
) (
  input  logic       clk,
  input  logic       rst,
  output logic [6:0] seg,
  output logic [4:0] dig_en,
  output logic       dp,
  output logic       alarm
);
  localparam int NDIG = 5;
  localparam int PW   = $clog2(CLK_PER_MS + 1);
  localparam int SW   = $clog2(SCAN_DIV + 1);

  logic [PW-1:0] pre;
  logic [SW-1:0] sc;
  logic [2:0]    idx;
  logic          tick, scan_step;
  logic [3:0]    dgt [NDIG];
  logic [3:0]    nxt [NDIG];
  logic [NDIG:0] carry;
  logic [3:0]    cur;

  assign tick      = (pre == PW'(CLK_PER_MS - 1));
  assign scan_step = (sc == SW'(SCAN_DIV - 1));
  assign carry[0]  = tick;

  always_ff @(posedge clk) begin
    if (rst)       pre <= '0;
    else if (tick) pre <= '0;
    else           pre <= pre + 1'b1;
  end

  genvar i;
  generate
    for (i = 0; i < NDIG; i++) begin : g_dig
      assign nxt[i]     = carry[i] ? ((dgt[i] == 4'd9) ? 4'd0 : dgt[i] + 4'd1) : dgt[i];
      assign carry[i+1] = carry[i] && (dgt[i] == 4'd9);
      always_ff @(posedge clk) begin
        if (rst) dgt[i] <= '0;
        else     dgt[i] <= nxt[i];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)       alarm <= 1'b0;
    else if (tick) alarm <= (nxt[4] == 4'd5) && (nxt[3] == 4'd0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sc  <= '0;
      idx <= '0;
    end else if (scan_step) begin
      sc  <= '0;
      idx <= (idx == 3'd4) ? 3'd0 : idx + 3'd1;
    end else begin
      sc  <= sc + 1'b1;
    end
  end

  always_comb begin
    case (idx)
      3'd0:    begin cur = dgt[0]; dig_en = 5'b00001; end
      3'd1:    begin cur = dgt[1]; dig_en = 5'b00010; end
      3'd2:    begin cur = dgt[2]; dig_en = 5'b00100; end
      3'd3:    begin cur = dgt[3]; dig_en = 5'b01000; end
      3'd4:    begin cur = dgt[4]; dig_en = 5'b10000; end
      default: begin cur = 4'd0;   dig_en = 5'b00000; end
    endcase
  end

  always_comb begin
    case (cur)
      4'd0:    seg = 7'h3F;
      4'd1:    seg = 7'h06;
      4'd2:    seg = 7'h5B;
      4'd3:    seg = 7'h4F;
      4'd4:    seg = 7'h66;
      4'd5:    seg = 7'h6D;
      4'd6:    seg = 7'h7D;
      4'd7:    seg = 7'h07;
      4'd8:    seg = 7'h7F;
      4'd9:    seg = 7'h6F;
      default: seg = 7'h00;
    endcase
  end

  assign dp = (idx == 3'd3);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (dgt[0] == 0 && dgt[1] == 0 && dgt[2] == 0 && dgt[3] == 0 && dgt[4] == 0 && !alarm));

  a_r2_hold_between_steps: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(dgt[0]));

  a_r3_bcd_range: assert property (@(posedge clk) disable iff (rst)
    (dgt[0] <= 9 && dgt[1] <= 9 && dgt[2] <= 9 && dgt[3] <= 9 && dgt[4] <= 9));

  a_r4_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
    (tick && dgt[4] == 9 && dgt[3] == 9 && dgt[2] == 9 && dgt[1] == 9 && dgt[0] == 9)
    |=> (dgt[4] == 0 && dgt[3] == 0 && dgt[2] == 0 && dgt[1] == 0 && dgt[0] == 0));

  a_r5_rise_at_fifty: assert property (@(posedge clk) disable iff (rst)
    $rose(alarm) |-> (dgt[4] == 5 && dgt[3] == 0 && dgt[2] == 0 && dgt[1] == 0 && dgt[0] == 0));

  a_r6_alarm_window: assert property (@(posedge clk) disable iff (rst)
    alarm == (dgt[4] == 5 && dgt[3] == 0));

  a_r7_onehot_enable: assert property (@(posedge clk) disable iff (rst)
    $onehot(dig_en));

  a_r9_dp_on_seconds: assert property (@(posedge clk) disable iff (rst)
    dp == dig_en[3]);
endmodule

// File: tb/tb_ms_seg_timer.sv
module tb_ms_seg_timer;
  localparam int CLK_PERIOD = 10;
  localparam int CPM_A = 1, SD_A = 3;
  localparam int CPM_B = 4, SD_B = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [6:0] seg_a, seg_b;
  logic [4:0] en_a, en_b;
  logic dp_a, dp_b, al_a, al_b;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ms_seg_timer #(.CLK_PER_MS(CPM_A), .SCAN_DIV(SD_A)) dut (
    .clk(clk), .rst(rst), .seg(seg_a), .dig_en(en_a), .dp(dp_a), .alarm(al_a));
  ms_seg_timer #(.CLK_PER_MS(CPM_B), .SCAN_DIV(SD_B)) dut_pre (
    .clk(clk), .rst(rst), .seg(seg_b), .dig_en(en_b), .dp(dp_b), .alarm(al_b));

  function automatic logic [6:0] code_of(int d);
    case (d)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
      8: return 7'h7F; default: return 7'h6F;
    endcase
  endfunction

  task automatic step(inout int pre, inout int ms, inout int sc, inout int idx,
                      inout bit al, input int cpm, input int sd, input bit r);
    if (r) begin
      pre = 0; ms = 0; sc = 0; idx = 0; al = 0;
    end else begin
      if (pre == cpm - 1) begin
        pre = 0;
        ms = (ms + 1) % 100000;
        al = (ms >= 50000 && ms < 51000);
      end else pre++;
      if (sc == sd - 1) begin
        sc = 0;
        idx = (idx + 1) % 5;
      end else sc++;
    end
  endtask

  task automatic compare(string who, int ms, int idx, bit al, bit was_rst,
                         logic [6:0] s, logic [4:0] e, logic d, logic a);
    int p = 1;
    logic [6:0] es;
    logic [4:0] ee;
    for (int k = 0; k < idx; k++) p = p * 10;
    es = code_of((ms / p) % 10);
    ee = 5'(1 << idx);
    total++;
    if (e !== ee) begin
      bad++;
      $display("FAIL %s %s dig_en actual=%b expected=%b", who, was_rst ? "R1" : "R7", e, ee);
    end else if (s !== es) begin
      bad++;
      $display("FAIL %s %s seg actual=%h expected=%h (ms=%0d)", who,
               was_rst ? "R1" : "R2/R3/R4/R8", s, es, ms);
    end else if (d !== (idx == 3)) begin
      bad++;
      $display("FAIL %s R9 dp actual=%b expected=%b", who, d, idx == 3);
    end else if (a !== al) begin
      bad++;
      $display("FAIL %s %s alarm actual=%b expected=%b (ms=%0d)", who,
               was_rst ? "R1" : "R5/R6", a, al, ms);
    end
  endtask

  int pa = 0, ma = 0, sa = 0, ia = 0;
  int pb = 0, mb = 0, sb = 0, ib = 0;
  bit la = 0, lb = 0;
  int high_cycles = 0;

  task automatic cycle();
    bit r;
    int prev_ms;
    @(posedge clk);
    r = rst;
    prev_ms = ma;
    step(pa, ma, sa, ia, la, CPM_A, SD_A, r);
    step(pb, mb, sb, ib, lb, CPM_B, SD_B, r);
    @(negedge clk);
    compare("dut", ma, ia, la, r, seg_a, en_a, dp_a, al_a);
    compare("dut_pre", mb, ib, lb, r, seg_b, en_b, dp_b, al_b);
    if (!r && al_a === 1'b1) high_cycles++;
    if (!r && prev_ms == 49999 && ma == 50000) begin
      total++;
      if (al_a !== 1'b1) begin bad++; $display("FAIL R5 alarm at 50.000 actual=%b expected=1", al_a); end
    end
    if (!r && prev_ms == 50999 && ma == 51000) begin
      total++;
      if (al_a !== 1'b0) begin bad++; $display("FAIL R6 alarm at 51.000 actual=%b expected=0", al_a); end
    end
    if (!r && prev_ms == 99999 && ma == 0) begin
      total++;
      if (en_a == 5'b00001 && seg_a !== 7'h3F) begin
        bad++; $display("FAIL R4 wrap seg actual=%h expected=3f", seg_a);
      end
    end
  endtask

  initial begin
    for (int k = 0; k < 3; k++) cycle();
    rst = 1'b0;
    for (int k = 0; k < 100200; k++) cycle();
    total++;
    if (high_cycles != 1000 * CPM_A) begin
      bad++;
      $display("FAIL R6 alarm high cycles actual=%0d expected=%0d", high_cycles, 1000 * CPM_A);
    end
    rst = 1'b1;
    for (int k = 0; k < 2; k++) cycle();
    rst = 1'b0;
    for (int k = 0; k < 1000; k++) cycle();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule